// File: doc/BRIEF.md
# Serial ADC Result Receiver

This block is the host-side controller for a 12-bit sampling converter that runs in serial-output mode and drives its own data clock. On request, the block pulls the converter's read/convert line low for a fixed number of system clock cycles. While the converter holds its busy line low, the block captures the serial bits that arrive with the converter's clock. When busy goes high again, the block hands over a 12-bit two's-complement word.

The data clock, data and busy lines are brought into the system clock domain through two-flop synchronizers. A bit is taken on each detected rising edge of the synchronized data clock. The word shifted out during a conversion is the result of the conversion before it. So the first transfer after reset has no requested conversion behind it and is dropped, and every word delivered later is the result of the previous conversion. A transfer that ends with a bit count other than 12 is dropped and reported as a framing error.

Convert requests are honoured only when the converter is idle (busy high) and enough time has passed since the last convert pulse. Any other request is dropped, not queued.

Top module: `adc_serial_rx`

## Requirements
- R1: A request accepted in idle drives `convN` low from the clock edge that samples the request, for exactly PULSE_CYC cycles, and then high again.
- R2: A request is ignored, leaving `convN` high, while synchronized busy is low, while a conversion or transfer is in progress, or within GAP_CYC cycles of the previous convert pulse.
- R3: Bits are captured only while synchronized busy is low and only after a convert pulse, one per rising edge of the synchronized data clock, first bit into the MSB.
- R4: When busy rises after exactly 12 captured bits, `sampleData` takes the captured word unchanged as two's complement, and `sampleValid` is high for one cycle, three clock edges after the busy input rises.
- R5: The first transfer completed after reset produces neither `sampleValid` nor `frameErr` when it has 12 bits. Each later word is the result of the conversion that came before the transfer.
- R6: When busy rises after a bit count other than 12, fewer or more, no word is delivered and `frameErr` is high for one cycle, at the same latency as R4.
- R7: During and right after reset, `convN` is 1, `sampleValid` and `frameErr` are 0, and `sampleData` is 0.
- R8: `sampleData` holds its value in every cycle where `sampleValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request for a conversion, sampled each cycle |
| dclkIn | input | 1 | Data clock driven by the converter (asynchronous) |
| sdataIn | input | 1 | Serial data from the converter (asynchronous) |
| busyIn | input | 1 | Converter busy, low during conversion and transfer (asynchronous) |
| convN | output | 1 | Read/convert strobe to the converter, active low |
| sampleData | output | 12 | Last delivered two's-complement result |
| sampleValid | output | 1 | One-cycle pulse when `sampleData` is updated |
| frameErr | output | 1 | One-cycle pulse when a transfer had the wrong bit count |

## Verification
`convN` responds on the first edge after a request is sampled. `sampleValid` and `frameErr` come three edges after the busy input rises: two synchronizer stages and the output register. A captured bit is seen two edges after the data clock input rises. The bench drives every input on the falling clock edge and samples outputs just before it drives. A behavioural reference, fed with the same inputs delayed by these stage counts, predicts every output for the following edge and is compared once per clock. A second layer of checks works on whole transfers. It compares each delivered word with the value the converter model received one conversion earlier, counts the cycles in each convert pulse, and counts the framing errors it expects.

// File: rtl/adc_serial_rx_pkg.sv
`timescale 1ns/1ps
package adc_serial_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAITLO = 2'd2,
    ST_RECV  = 2'd3
  } rxState_e;

  typedef struct packed {
    logic clr;
    logic capEn;
    logic load;
    logic err;
  } rxStrobe_t;

endpackage

// File: rtl/adc_serial_rx_sync.sv
`timescale 1ns/1ps
module adc_serial_rx_sync #(
  parameter int BITS   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] dout
);

  generate
    for (genvar i = 0; i < BITS; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din[i]};
      end
      assign dout[i] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/adc_serial_rx_ctrl.sv
`timescale 1ns/1ps
module adc_serial_rx_ctrl
  import adc_serial_rx_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  parameter int GAP_CYC   = 1250
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      busySync,
  input  logic      cntOk,
  output logic      convN,
  output rxStrobe_t strobe
);

  localparam int PULSE_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  rxState_e           state;
  logic [PULSE_W-1:0] pulseCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               primed;
  logic               convNq;
  logic               busyPrev;

  logic gapOk, busyRise, launch, pulseLast;

  assign gapOk     = (gapCnt == GAP_W'(GAP_CYC));
  assign busyRise  = busySync & ~busyPrev;
  assign launch    = (state == ST_IDLE) & startReq & gapOk & busySync;
  assign pulseLast = (pulseCnt == PULSE_W'(PULSE_CYC - 1));

  always_comb begin
    strobe       = '0;
    strobe.clr   = launch;
    strobe.capEn = ~busySync & ((state == ST_WAITLO) | (state == ST_RECV));
    if (state == ST_RECV && busyRise) begin
      strobe.load = cntOk & primed;
      strobe.err  = ~cntOk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pulseCnt <= '0;
      gapCnt   <= GAP_W'(GAP_CYC);
      primed   <= 1'b0;
      convNq   <= 1'b1;
      busyPrev <= 1'b0;
    end else begin
      busyPrev <= busySync;
      if (launch)      gapCnt <= '0;
      else if (!gapOk) gapCnt <= gapCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state    <= ST_PULSE;
            pulseCnt <= '0;
            convNq   <= 1'b0;
          end
        end
        ST_PULSE: begin
          if (pulseLast) begin
            state  <= ST_WAITLO;
            convNq <= 1'b1;
          end else begin
            pulseCnt <= pulseCnt + 1'b1;
          end
        end
        ST_WAITLO: begin
          if (!busySync) state <= ST_RECV;
        end
        ST_RECV: begin
          if (busyRise) begin
            state  <= ST_IDLE;
            primed <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convN = convNq;

  // R1: a convert pulse only begins after a request was sampled
  p_pulse_from_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convN) |-> $past(startReq));

  // R2: no pulse may begin while the converter reports busy
  p_no_launch_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (convN && !busySync) |=> convN);

  // R6: a completion is either a word or an error, never both
  p_load_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.err));

endmodule

// File: rtl/adc_serial_rx_dpath.sv
`timescale 1ns/1ps
module adc_serial_rx_dpath
  import adc_serial_rx_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dclkSync,
  input  logic             sdataSync,
  input  rxStrobe_t        strobe,
  output logic             cntOk,
  output logic [WIDTH-1:0] sampleData,
  output logic             sampleValid,
  output logic             frameErr
);

  localparam int CNT_W = $clog2(WIDTH + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WIDTH + 1);

  logic [WIDTH-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;
  logic             dclkPrev;
  logic             dclkRise;

  assign dclkRise = dclkSync & ~dclkPrev;
  assign cntOk    = (bitCnt == CNT_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      dclkPrev <= 1'b0;
    end else begin
      dclkPrev <= dclkSync;
      if (strobe.clr) begin
        shiftReg <= '0;
        bitCnt   <= '0;
      end else if (strobe.capEn && dclkRise) begin
        shiftReg <= {shiftReg[WIDTH-2:0], sdataSync};
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleData  <= '0;
      sampleValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      sampleValid <= strobe.load;
      frameErr    <= strobe.err;
      if (strobe.load) sampleData <= shiftReg;
    end
  end

  // R3: the bit counter never runs past its saturation value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT);

  // R4: a delivered word is a single-cycle pulse
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R6: a framing error never accompanies a word
  p_valid_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && frameErr));

  // R8: the output word holds between deliveries
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleData));

endmodule

// File: rtl/adc_serial_rx.sv
`timescale 1ns/1ps
module adc_serial_rx
  import adc_serial_rx_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYC   = 4,
  parameter int GAP_CYC     = 1250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             dclkIn,
  input  logic             sdataIn,
  input  logic             busyIn,
  output logic             convN,
  output logic [WIDTH-1:0] sampleData,
  output logic             sampleValid,
  output logic             frameErr
);

  logic [2:0] rawIn;
  logic [2:0] syncOut;
  rxStrobe_t  strobe;
  logic       cntOk;

  assign rawIn = {busyIn, sdataIn, dclkIn};

  adc_serial_rx_sync #(.BITS(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncOut)
  );

  adc_serial_rx_ctrl #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .busySync(syncOut[2]),
    .cntOk   (cntOk),
    .convN   (convN),
    .strobe  (strobe)
  );

  adc_serial_rx_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .dclkSync   (syncOut[0]),
    .sdataSync  (syncOut[1]),
    .strobe     (strobe),
    .cntOk      (cntOk),
    .sampleData (sampleData),
    .sampleValid(sampleValid),
    .frameErr   (frameErr)
  );

endmodule

// File: tb/sim_adc_serial_rx.sv
`timescale 1ns/1ps
module sim_adc_serial_rx;

  localparam int W     = 12;
  localparam int PULSE = 3;
  localparam int GAP   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, dclkIn = 1'b0, sdataIn = 1'b0, busyIn = 1'b1;
  logic convN, sampleValid, frameErr;
  logic [W-1:0] sampleData;

  always #10 clk = ~clk;

  adc_serial_rx #(.WIDTH(W), .SYNC_STAGES(2), .PULSE_CYC(PULSE), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dclkIn(dclkIn),
    .sdataIn(sdataIn), .busyIn(busyIn), .convN(convN),
    .sampleData(sampleData), .sampleValid(sampleValid), .frameErr(frameErr)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  int mState, mPulse, mGap, mShift, mCnt;
  bit mPrimed, mConvN, mValid, mErr;
  int mData;
  bit hB[4], hD[4], hS[4];

  // transfer-level bookkeeping
  logic [W-1:0] expQ[$];
  int errExp = 0;
  int lowCount = 0;
  bit primedB = 0;
  logic [W-1:0] lastVal = 12'hABC;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mState = 0; mPulse = 0; mGap = GAP; mShift = 0; mCnt = 0;
    mPrimed = 0; mConvN = 1; mValid = 0; mErr = 0; mData = 0;
    for (int i = 0; i < 4; i++) begin hB[i] = 0; hD[i] = 0; hS[i] = 0; end
  endtask

  task automatic modelStep();
    bit sb, pb, sdk, pdk, sd, bRise, dRise, capEn, launch, load, err;
    int nState, nPulse, nGap, nShift, nCnt;
    bit nPrimed, nConvN;
    for (int i = 3; i > 0; i--) begin hB[i] = hB[i-1]; hD[i] = hD[i-1]; hS[i] = hS[i-1]; end
    hB[0] = busyIn; hD[0] = dclkIn; hS[0] = sdataIn;
    sb = hB[2]; pb = hB[3]; sdk = hD[2]; pdk = hD[3]; sd = hS[2];
    bRise = sb && !pb;
    dRise = sdk && !pdk;
    capEn = !sb && (mState == 2 || mState == 3);
    launch = (mState == 0) && startReq && (mGap == GAP) && sb;
    load = (mState == 3) && bRise && (mCnt == W) && mPrimed;
    err  = (mState == 3) && bRise && (mCnt != W);
    nState = mState; nPulse = mPulse; nPrimed = mPrimed; nConvN = mConvN;
    nGap = launch ? 0 : ((mGap < GAP) ? mGap + 1 : mGap);
    nShift = mShift; nCnt = mCnt;
    if (launch) begin nShift = 0; nCnt = 0; end
    else if (capEn && dRise) begin
      nShift = ((mShift << 1) | sd) & 12'hFFF;
      if (mCnt < W + 1) nCnt = mCnt + 1;
    end
    case (mState)
      0: if (launch) begin nState = 1; nPulse = 0; nConvN = 0; end
      1: if (mPulse == PULSE - 1) begin nState = 2; nConvN = 1; end
         else nPulse = mPulse + 1;
      2: if (!sb) nState = 3;
      default: if (bRise) begin nState = 0; nPrimed = 1; end
    endcase
    mValid = load; mErr = err;
    if (load) mData = mShift;
    mState = nState; mPulse = nPulse; mGap = nGap; mShift = nShift;
    mCnt = nCnt; mPrimed = nPrimed; mConvN = nConvN;
  endtask

  // one clock: sample and compare, then drive, then advance the reference
  task automatic tick(input bit st, input bit bz, input bit dk, input bit sd);
    @(negedge clk);
    check("R1 convN vs reference", convN, mConvN);
    check("R4 sampleValid vs reference", sampleValid, mValid);
    check("R8 sampleData vs reference", sampleData, mData);
    check("R6 frameErr vs reference", frameErr, mErr);
    if (!convN) lowCount++;
    if (sampleValid) begin
      if (expQ.size() == 0) check("R5 unexpected word", sampleData, -1);
      else check("R4 delivered word is previous conversion", sampleData, expQ.pop_front());
    end
    if (frameErr) begin
      if (errExp == 0) check("R6 unexpected frameErr", 1, 0);
      else errExp--;
    end
    startReq = st; busyIn = bz; dclkIn = dk; sdataIn = sd;
    if (!rstN) modelReset(); else modelStep();
  endtask

  task automatic doReset();
    rstN = 0;
    modelReset();
    for (int i = 0; i < 4; i++) tick(0, 1, 0, 0);
    check("R7 reset convN", convN, 1);
    check("R7 reset sampleValid", sampleValid, 0);
    check("R7 reset frameErr", frameErr, 0);
    check("R7 reset sampleData", sampleData, 0);
    rstN = 1;
    expQ.delete(); errExp = 0; primedB = 0; lastVal = 12'hABC;
    for (int i = 0; i < 6; i++) tick(0, 1, 0, 0);
  endtask

  // one convert command plus the converter's answer; transfer carries lastVal
  task automatic convert(input logic [W-1:0] newVal, input int nbits,
                         input bit reqInXfer, input int idleAfter);
    logic [W-1:0] w;
    w = lastVal;
    lowCount = 0;
    tick(1, 1, 0, 0);
    for (int i = 0; i < PULSE + 2; i++) tick(0, 1, 0, 0);
    check("R1 convert pulse length", lowCount, PULSE);
    lowCount = 0;
    for (int i = 0; i < 3; i++) tick(reqInXfer, 0, 0, 0);
    for (int i = 0; i < nbits; i++) begin
      bit b;
      b = (i < W) ? w[W-1-i] : 1'b1;
      tick(reqInXfer, 0, 0, b); tick(reqInXfer, 0, 0, b);
      tick(reqInXfer, 0, 1, b); tick(reqInXfer, 0, 1, b);
    end
    tick(0, 0, 0, 0); tick(0, 0, 0, 0);
    check("R2 no pulse during transfer", lowCount, 0);
    if (nbits == W && primedB) expQ.push_back(w);
    else if (nbits != W) errExp++;
    primedB = 1;
    lastVal = newVal;
    tick(0, 1, 0, 0);
    for (int i = 0; i < idleAfter; i++) tick(0, 1, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();
    // R5: first transfer (junk) is dropped; later words lag by one conversion
    convert(12'h7FF, 12, 0, GAP);
    convert(12'h800, 12, 1, GAP);     // R2: requests during the transfer ignored
    convert(12'h001, 12, 0, GAP);
    convert(12'h5A5, 10, 0, GAP);     // R6: short frame
    convert(12'h3C3, 12, 0, GAP);
    // R2: request within the spacing window after a quick transfer
    convert(12'h0F0, 2, 0, 1);
    lowCount = 0;
    tick(1, 1, 0, 0);
    for (int i = 0; i < 6; i++) tick(0, 1, 0, 0);
    check("R2 request inside spacing ignored", lowCount, 0);
    for (int i = 0; i < GAP; i++) tick(0, 1, 0, 0);
    convert(12'h123, 13, 0, GAP);     // R6: long frame
    convert(12'hFFE, 12, 0, GAP);
    // R2: request while the converter holds busy low on its own
    lowCount = 0;
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) tick(0, 1, 0, 0);
    check("R2 request with busy low ignored", lowCount, 0);
    for (int i = 0; i < 4; i++) tick(0, 1, 0, 0);
    convert(12'h456, 12, 0, GAP);
    // R5 again after a fresh reset
    doReset();
    convert(12'h321, 12, 0, GAP);
    convert(12'h000, 12, 0, GAP);
    for (int i = 0; i < 6; i++) tick(0, 1, 0, 0);
    check("R4 all expected words delivered", expQ.size(), 0);
    check("R6 all expected errors seen", errExp, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule